// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running counter with a programmable clock divider in front of it and a small set of compare channels. The divider counts system clocks up to a programmed limit; each time it reaches that limit the main counter steps by one, so the main counter advances once every limit+1 enabled clocks. Each compare channel holds a target value. When the main counter sits on that target and the divider is about to step, the channel produces a one-cycle event. Depending on three per-channel action bits, the event also latches an interrupt flag, sends the counter back to zero on that step, and halts counting.

Software reaches every setting and both counters through a simple register bus with a combinational read. A run bit and a hold-at-zero bit in the control register start, pause and clear the counters. Pending interrupt flags are read from a flag register and cleared by writing ones to it. A single interrupt line is the OR of the pending flags, and every channel also drives a raw event pulse so that neighbouring logic can use it.

Top module: `mt_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and no `match_evt` bit is high. The byte offsets are: flags 0x00, control 0x04, main counter 0x08, divider limit 0x0C, divider counter 0x10, action control 0x14, and target n at 0x18+4n.
- R2: While counting is enabled, the divider counter rises by one per clock. In the clock where it equals the limit, it returns to 0 and the main counter rises by one, so the main counter steps once every limit+1 clocks. Counting is enabled when control bit 0 is 1 and control bit 1 is 0.
- R3: `match_evt[n]` is high for exactly the clock in which counting is enabled, the divider counter equals the limit and the main counter equals target n. This holds whatever the action bits are.
- R4: Action bit 3n is the interrupt enable for channel n. When it is set, an event on channel n sets flag bit n at offset 0x00, and `irq` is high while any flag is set. Flag bits at n ≥ 4 read 0, and an event whose interrupt enable is clear sets no flag.
- R5: Writing to offset 0x00 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. An event in the same clock as a clearing write leaves its flag set.
- R6: Action bit 3n+1 makes an event on channel n load 0 into the main counter at that step, in place of the increment.
- R7: Action bit 3n+2 makes an event on channel n stop counting. The main counter keeps the target value, the divider counter returns to 0, and control bit 0 reads 0 afterwards.
- R8: While control bit 1 is 1, both counters are 0 from the next clock on. No events occur, and writes to the counters are overridden.
- R9: A bus write to offset 0x08 or 0x10 loads the main counter or the divider counter with the written data.
- R10: With control bit 0 at 0, both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational from bus_addr |
| irq | output | 1 | High while any flag is pending |
| match_evt | output | NCH (4) | One-clock event pulse per compare channel |

## Verification
The hardest case to reach from the ports is a clearing write to the flag register that falls in exactly the clock in which the same channel fires. The bench's reference model predicts the next event from its own state. When the model predicts that event for the coming edge, the bench issues the clearing write in that cycle and then reads the flag back. Halting on a target and wrapping from a target are reached by loading the counters over the bus next to small targets. Wrap-around at the counter's full width is reached by preloading a value just below the top.

// File: rtl/mt_pkg.sv
// Package: shared constants and types for the prescaled match timer.
// Assumes byte addressing with 4-byte register spacing.
package mt_pkg;
    localparam logic [7:0] OFS_FLAG = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h04;
    localparam logic [7:0] OFS_TC   = 8'h08;
    localparam logic [7:0] OFS_PR   = 8'h0C;
    localparam logic [7:0] OFS_PC   = 8'h10;
    localparam logic [7:0] OFS_ACT  = 8'h14;
    localparam logic [7:0] OFS_TGT0 = 8'h18;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_HOLD_BIT = 1;
    localparam int ACT_BITS      = 3;

    // Per-channel action bits; bit 0 interrupt, bit 1 wrap, bit 2 halt.
    typedef struct packed {
        logic halt;
        logic wrap;
        logic irq;
    } mt_act_t;
endpackage

// File: rtl/mt_prescaler.sv
// Module: divider counter. Counts enabled clocks and raises `tick` in the
// clock where its value equals `limit`. Assumes hold overrides a bus load.
module mt_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         hold,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pc,
    output logic         tick
);
    // Terminal-count detection.
    assign tick = cnt_en && (pc == limit);

    // Divider counter update: hold, load, restart, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (hold)   pc <= '0;
        else if (ld)     pc <= ld_val;
        else if (tick)   pc <= '0;
        else if (cnt_en) pc <= pc + 1'b1;
    end
endmodule

// File: rtl/mt_tcounter.sv
// Module: main counter. Steps on each divider tick unless a channel asks
// for a wrap to zero or a halt. Assumes wrap has priority over halt.
module mt_tcounter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         tick,
    input  logic         wrap,
    input  logic         halt,
    output logic [W-1:0] tc
);
    // Main counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)    tc <= '0;
        else if (hold) tc <= '0;
        else if (ld)   tc <= ld_val;
        else if (tick) begin
            if (wrap)      tc <= '0;
            else if (halt) tc <= tc;
            else           tc <= tc + 1'b1;
        end
    end
endmodule

// File: rtl/mt_match_chan.sv
// Module: one compare channel. Detects a hit on a divider tick, requests
// actions and keeps the interrupt flag. Assumes set beats clear.
module mt_match_chan #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   tc,
    input  logic [W-1:0]   target,
    input  logic           tick,
    input  mt_pkg::mt_act_t act,
    input  logic           flag_clr,
    output logic           hit,
    output logic           wrap_req,
    output logic           halt_req,
    output logic           flag
);
    // Compare on the tick so that each target value gives one event.
    assign hit      = tick && (tc == target);
    assign wrap_req = hit && act.wrap;
    assign halt_req = hit && act.halt;

    // Sticky interrupt flag; a new event beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !flag_clr) || (hit && act.irq);
    end
endmodule

// File: rtl/mt_timer.sv
// Module: top of the prescaled match timer. Holds the register file,
// decodes the bus and ties the divider, counter and channels together.
// Assumes single-cycle writes and a combinational read path.
module mt_timer #(
    parameter int W      = 32,
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq,
    output logic [NCH-1:0]    match_evt
);
    import mt_pkg::*;

    localparam int ACT_W = ACT_BITS * NCH;
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TC   = ADDR_W'(OFS_TC);
    localparam logic [ADDR_W-1:0] A_PR   = ADDR_W'(OFS_PR);
    localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(OFS_PC);
    localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(OFS_ACT);

    logic             wr;
    logic             run_q, hold_q, cnt_en, tick;
    logic [W-1:0]     pr_q, pc_q, tc_q;
    logic [ACT_W-1:0] act_q;
    logic [W-1:0]     tgt_q [NCH];
    logic [NCH-1:0]   hit, wrap_req, halt_req, flag, tgt_wr;
    logic             any_wrap, any_halt;

    assign wr       = bus_sel && bus_wr;
    assign cnt_en   = run_q && !hold_q;
    assign any_wrap = |wrap_req;
    assign any_halt = |halt_req;

    // Control register: run bit (cleared by a halting event) and hold bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (any_halt)                    run_q <= 1'b0;
            else if (wr && bus_addr == A_CTRL) run_q <= bus_wdata[CTRL_RUN_BIT];
            if (wr && bus_addr == A_CTRL)    hold_q <= bus_wdata[CTRL_HOLD_BIT];
        end
    end

    // Divider limit and action control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q  <= '0;
            act_q <= '0;
        end else begin
            if (wr && bus_addr == A_PR)  pr_q  <= bus_wdata;
            if (wr && bus_addr == A_ACT) act_q <= bus_wdata[ACT_W-1:0];
        end
    end

    mt_prescaler #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .hold   (hold_q),
        .ld     (wr && bus_addr == A_PC),
        .ld_val (bus_wdata),
        .limit  (pr_q),
        .pc     (pc_q),
        .tick   (tick)
    );

    mt_tcounter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold_q),
        .ld     (wr && bus_addr == A_TC),
        .ld_val (bus_wdata),
        .tick   (tick),
        .wrap   (any_wrap),
        .halt   (any_halt),
        .tc     (tc_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        localparam logic [ADDR_W-1:0] A_TGT = ADDR_W'(OFS_TGT0 + 4 * n);
        assign tgt_wr[n] = wr && bus_addr == A_TGT;

        // Target register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)         tgt_q[n] <= '0;
            else if (tgt_wr[n]) tgt_q[n] <= bus_wdata;
        end

        mt_match_chan #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tc       (tc_q),
            .target   (tgt_q[n]),
            .tick     (tick),
            .act      (mt_act_t'(act_q[ACT_BITS*n +: ACT_BITS])),
            .flag_clr (wr && bus_addr == A_FLAG && bus_wdata[n]),
            .hit      (hit[n]),
            .wrap_req (wrap_req[n]),
            .halt_req (halt_req[n]),
            .flag     (flag[n])
        );
    end

    assign match_evt = hit;
    assign irq       = |flag;

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_FLAG) bus_rdata = W'(flag);
        if (bus_addr == A_CTRL) bus_rdata = W'({hold_q, run_q});
        if (bus_addr == A_TC)   bus_rdata = tc_q;
        if (bus_addr == A_PR)   bus_rdata = pr_q;
        if (bus_addr == A_PC)   bus_rdata = pc_q;
        if (bus_addr == A_ACT)  bus_rdata = W'(act_q);
        for (int n = 0; n < NCH; n++)
            if (bus_addr == ADDR_W'(OFS_TGT0 + 4 * n)) bus_rdata = tgt_q[n];
    end
endmodule

// File: rtl/mt_timer_chk.sv
// Module: assertion checker for mt_timer, attached with a bind below.
module mt_timer_chk #(
    parameter int W   = 32,
    parameter int NCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr,
    input logic                 run_q,
    input logic                 hold_q,
    input logic [W-1:0]         pc_q,
    input logic [W-1:0]         pr_q,
    input logic [W-1:0]         tc_q,
    input logic [3*NCH-1:0]     act_q,
    input logic [NCH-1:0]       match_evt,
    input logic                 irq
);
    logic [NCH-1:0] halt_m;
    // Gather the halt enables of all channels.
    always_comb
        for (int n = 0; n < NCH; n++) halt_m[n] = act_q[3*n+2];

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> (tc_q == '0 && pc_q == '0));
    assert_evt_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_evt) |-> (run_q && !hold_q && pc_q == pr_q));
    assert_halt_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_evt & halt_m)) |=> !run_q);
    assert_irq_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|match_evt));
    assert_tc_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !hold_q && pc_q != pr_q) |=> $stable(tc_q));
endmodule

bind mt_timer mt_timer_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .run_q     (run_q),
    .hold_q    (hold_q),
    .pc_q      (pc_q),
    .pr_q      (pr_q),
    .tc_q      (tc_q),
    .act_q     (act_q),
    .match_evt (match_evt),
    .irq       (irq)
);

// File: tb/test_mt_timer.sv
module test_mt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [3:0]  evt;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mt_timer i_mt_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq(irq), .match_evt(evt)
    );

    // Behavioural reference model, stepped on each rising edge.
    logic [31:0] m_pc, m_tc, m_pr;
    logic [31:0] m_tgt [4];
    logic [11:0] m_act;
    logic        m_run, m_hold;
    logic [3:0]  m_flag;

    function automatic logic [3:0] pred_evt();
        logic [3:0] r = '0;
        if (m_run && !m_hold && m_pc == m_pr)
            for (int n = 0; n < 4; n++) r[n] = (m_tc == m_tgt[n]);
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {28'd0, m_flag};
            8'h04: return {30'd0, m_hold, m_run};
            8'h08: return m_tc;
            8'h0C: return m_pr;
            8'h10: return m_pc;
            8'h14: return {20'd0, m_act};
            8'h18: return m_tgt[0];
            8'h1C: return m_tgt[1];
            8'h20: return m_tgt[2];
            8'h24: return m_tgt[3];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_tc = 0; m_pr = 0; m_act = 0; m_run = 0; m_hold = 0; m_flag = 0;
            for (int n = 0; n < 4; n++) m_tgt[n] = 0;
        end else begin
            logic [3:0] e;
            logic w, wrap, halt, tick;
            e = pred_evt();
            w = sel && wr;
            tick = m_run && !m_hold && m_pc == m_pr;
            wrap = 0; halt = 0;
            for (int n = 0; n < 4; n++) begin
                if (e[n] && m_act[3*n+1]) wrap = 1;
                if (e[n] && m_act[3*n+2]) halt = 1;
            end
            if (m_hold) begin m_tc = 0; end
            else if (w && addr == 8'h08) m_tc = wdata;
            else if (tick) m_tc = wrap ? 0 : (halt ? m_tc : m_tc + 1);
            if (m_hold) m_pc = 0;
            else if (w && addr == 8'h10) m_pc = wdata;
            else if (tick) m_pc = 0;
            else if (m_run) m_pc = m_pc + 1;
            for (int n = 0; n < 4; n++) begin
                if (w && addr == 8'h00 && wdata[n]) m_flag[n] = 0;
                if (e[n] && m_act[3*n]) m_flag[n] = 1;
                if (w && addr == 8'h18 + 8'(4*n)) m_tgt[n] = wdata;
            end
            if (w && addr == 8'h04) m_hold = wdata[1];
            if (halt) m_run = 0;
            else if (w && addr == 8'h04) m_run = wdata[0];
            if (w && addr == 8'h0C) m_pr = wdata;
            if (w && addr == 8'h14) m_act = wdata[11:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare the outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] pe;
            pe = pred_evt();
            chk(evt == pe, "R3 event pulse", {28'd0, evt}, {28'd0, pe});
            chk(irq == |m_flag, "R4 irq line", {31'd0, irq}, {31'd0, |m_flag});
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
        sel = 0;
    endtask

    task automatic rd_model(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1;
        e = m_read(a);
        chk(rdata == e, tag, rdata, e);
        sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: every register reads zero after reset
        for (int a = 0; a <= 8'h24; a += 4) rd_lit(8'(a), 32'd0, "R1 reset value");
        chk(irq == 0 && evt == 0, "R1 outputs idle", {27'd0, irq, evt}, 32'd0);

        // R2/R6/R4: limit 2, target0=5 with interrupt+wrap, target2=3 no action
        bus_write(8'h0C, 32'd2);
        bus_write(8'h18, 32'd5);
        bus_write(8'h20, 32'd3);
        bus_write(8'h14, 32'h003);
        bus_write(8'h04, 32'd1);
        idle(7);
        rd_model(8'h10, "R2 divider counter");
        rd_model(8'h08, "R2 main counter");
        idle(20);
        rd_model(8'h08, "R6 wrap keeps counter at or below target");
        rd_lit(8'h00, 32'h1, "R4 flag 0 only (channel 2 has no interrupt enable)");

        // R5: write of 0 leaves flag, write of 1 clears it
        bus_write(8'h04, 32'd0);
        bus_write(8'h00, 32'h0);
        rd_lit(8'h00, 32'h1, "R5 zero write keeps flag");
        bus_write(8'h00, 32'h1);
        rd_lit(8'h00, 32'h0, "R5 one write clears flag");

        // R7: channel 1 target 7 with interrupt and halt
        bus_write(8'h1C, 32'd7);
        bus_write(8'h14, 32'h028);
        bus_write(8'h08, 32'd0);
        bus_write(8'h10, 32'd0);
        bus_write(8'h04, 32'd1);
        idle(40);
        rd_lit(8'h04, 32'd0, "R7 run bit cleared");
        rd_lit(8'h08, 32'd7, "R7 counter kept target");
        rd_lit(8'h10, 32'd0, "R7 divider returned to zero");
        rd_lit(8'h00, 32'h2, "R7 flag of halting channel");

        // R10: disabled counters keep their values
        bus_write(8'h08, 32'd20);
        idle(10);
        rd_lit(8'h08, 32'd20, "R10 counter still while stopped");

        // R8: hold clears and keeps zero even against a load
        bus_write(8'h04, 32'd3);
        idle(4);
        rd_lit(8'h08, 32'd0, "R8 counter held at zero");
        bus_write(8'h10, 32'd9);
        rd_lit(8'h10, 32'd0, "R8 divider held at zero");
        bus_write(8'h04, 32'd0);

        // R9: bus loads, then wrap at full width with limit 0
        bus_write(8'h00, 32'hF);
        bus_write(8'h14, 32'h0);
        bus_write(8'h0C, 32'd0);
        bus_write(8'h08, 32'hFFFF_FFFE);
        rd_lit(8'h08, 32'hFFFF_FFFE, "R9 counter load");
        bus_write(8'h10, 32'd5);
        rd_lit(8'h10, 32'd5, "R9 divider load");
        bus_write(8'h10, 32'd0);
        bus_write(8'h04, 32'd1);
        idle(4);
        rd_model(8'h08, "R2 full-width wrap");

        // R5: clearing write in the very clock of an event keeps the flag
        bus_write(8'h04, 32'd0);
        bus_write(8'h08, 32'd0);
        bus_write(8'h18, 32'd3);
        bus_write(8'h14, 32'h003);
        bus_write(8'h04, 32'd1);
        begin
            bit hit_done = 0;
            for (int i = 0; i < 50 && !hit_done; i++) begin
                logic [3:0] pe;
                @(negedge clk);
                pe = pred_evt();
                if (pe[0]) begin
                    sel = 1; wr = 1; addr = 8'h00; wdata = 32'h1;
                    @(negedge clk);
                    sel = 0; wr = 0;
                    hit_done = 1;
                end
            end
            chk(hit_done, "R5 collision reached", {31'd0, hit_done}, 32'd1);
        end
        rd_lit(8'h00, 32'h1, "R5 event beats clear");
        rd_model(8'h08, "R6 counter after wrap");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule